// File: doc/BRIEF.md
# Two-Channel Edge Tally Counter

This block turns activity on external digital lines into a signed 16-bit count. It has two counting channels. Each channel watches one edge input and one control input. Both inputs can be inverted, then pass through a two-stage synchroniser and an optional glitch filter. For each channel, the rising edge and the falling edge each select their own action. The filtered control level can keep that action, reverse it or suppress it. Every cycle, the counter adds the net step of both channels.

Software sets up the block through a plain write-only register port. The port holds:
- a configuration word for each channel;
- the wrap limits and two compare thresholds;
- the filter setting and the event enables;
- a status-acknowledge strobe;
- a run-control word that pauses the count or holds it at zero.

The count, the latched event status, the zero-approach code and one interrupt line are plain outputs. Two channels set up as mirror images decode a quadrature A/B pair. Channel 0 counts on A and is gated by B; channel 1 counts on B and is gated by A. This gives four counts per encoder period, signed by direction.

Top module: `edge_tally_unit`

## Requirements
- R1: A channel word sits at address 0 (channel 0) or 1 (channel 1). Bits [1:0] set the rising-edge action and bits [3:2] the falling-edge action, with 0 = hold, 1 = add one, 2 = subtract one and 3 = hold.
- R2: Bits [5:4] of a channel word give the mode used while the control level is low, and bits [7:6] the mode used while it is high. The modes are 0 = keep the edge action, 1 = reverse its sign, 2 or 3 = suppress counting.
- R3: Bit 8 of a channel word inverts the edge input and bit 9 inverts the control input. Inversion acts before synchronisation, edge detection and level decoding.
- R4: When both channels yield a step in the same cycle, the count moves by their net sum, from -2 to +2, in that one cycle.
- R5: Address 2 holds the low limit in bits [15:0] and the high limit in bits [31:16]. Both are signed, the low limit negative and the high limit positive. A step that reaches or passes a limit sets the count to 0 and raises that limit's event.
- R6: Address 3 holds threshold 0 in bits [15:0] and threshold 1 in bits [31:16]. A threshold event, or the zero event, fires only in the cycle the count moves onto that value from a different value.
- R7: zero_mode_o reports the last count change. 0 means the count moved from positive to zero, 1 means from negative to zero, 2 means it is now negative and 3 means it is now positive. It is 0 after reset.
- R8: Address 4 bits [15:11] enable the events low limit, high limit, threshold 0, threshold 1 and zero, in that order. An enabled event sets the status_o bit of the same index (0 to 4). irq_o is high whenever any status bit is set.
- R9: Writing 1 to bit 0 of address 5 clears all status bits. A write to any of addresses 0 to 4 also clears them. An event in the same cycle still sets its bit.
- R10: Address 4 bit 10 enables the glitch filter and bits [9:0] set its threshold in clock cycles. With the filter on, a synchronised level must persist for that many cycles before it is accepted, so shorter pulses are not counted.
- R11: Address 6 bit 0 pauses the count. While paused the count keeps its value and edges are lost.
- R12: Address 6 bit 1 forces the count to 0 and holds it there while set. It takes priority over pause.
- R13: The mirror configuration decodes quadrature. Channel 0 uses rise = subtract and fall = add; channel 1 uses rise = add and fall = subtract. In both, low control reverses and high control keeps. One A-leading period then moves the count by +4, and one B-leading period by -4.
- R14: After reset the count, status, irq_o and zero_mode_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| edge_in | input | 2 | Edge input, one per channel |
| ctrl_in | input | 2 | Control input, one per channel |
| count_o | output | 16 | Signed count value |
| status_o | output | 5 | Latched event bits (low, high, thr0, thr1, zero) |
| zero_mode_o | output | 2 | Zero-approach code |
| irq_o | output | 1 | Interrupt, OR of status bits |

## Verification
Two things can land on the counter in the same clock: a step from channel 0 and a step from channel 1. The bench forces this by driving both edge inputs from one shared waveform, so both channels detect their edges on the same cycle. It judges the outcome by the final count. Equal actions must give twice the pulse count, and opposite actions must leave the count unchanged. A second kind of overlap is a threshold or limit event arriving at the moment of a wrap. The bench checks this through the status bits after sequences that land exactly on the limits.

// File: rtl/tally_pkg.sv
package tally_pkg;

  localparam int N_EVT    = 5;
  localparam int EVT_LO   = 0;
  localparam int EVT_HI   = 1;
  localparam int EVT_T0   = 2;
  localparam int EVT_T1   = 3;
  localparam int EVT_ZERO = 4;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_INC  = 2'd1,
    ACT_DEC  = 2'd2,
    ACT_RSVD = 2'd3
  } edge_act_e;

  typedef enum logic [1:0] {
    CM_KEEP = 2'd0,
    CM_FLIP = 2'd1,
    CM_STOP = 2'd2,
    CM_RSVD = 2'd3
  } ctl_mode_e;

  typedef enum logic [1:0] {
    ZM_POS_TO_ZERO = 2'd0,
    ZM_NEG_TO_ZERO = 2'd1,
    ZM_NEG         = 2'd2,
    ZM_POS         = 2'd3
  } zero_mode_e;

  // Field order is the channel word layout software writes.
  typedef struct packed {
    logic      inv_ctl;
    logic      inv_edge;
    ctl_mode_e hi_mode;
    ctl_mode_e lo_mode;
    edge_act_e fall_act;
    edge_act_e rise_act;
  } chan_cfg_t;

  localparam int CHAN_CFG_W = $bits(chan_cfg_t);

endpackage

// File: rtl/tally_sig_cond.sv
module tally_sig_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_i,
  input  logic              invert_i,
  input  logic              filt_en_i,
  input  logic [FILT_W-1:0] filt_thr_i,
  output logic              level_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic [FILT_W-1:0]      run_q;
  logic                   level_q;
  logic [FILT_W:0]        run_next;
  logic                   bypass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= raw_i ^ invert_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign synced   = sync_q[SYNC_STAGES-1];
  assign run_next = {1'b0, run_q} + 1'b1;
  assign bypass   = !filt_en_i || (filt_thr_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      run_q   <= '0;
    end else if (bypass) begin
      level_q <= synced;
      run_q   <= '0;
    end else if (synced == level_q) begin
      run_q   <= '0;
    end else if (run_next >= {1'b0, filt_thr_i}) begin
      level_q <= synced;
      run_q   <= '0;
    end else begin
      run_q   <= run_next[FILT_W-1:0];
    end
  end

  assign level_o = level_q;

  // R10: with a threshold of two or more, an accepted level survives at least one more cycle
  a_r10_filter_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) && filt_en_i && (filt_thr_i > 1) && $stable(filt_en_i)
      && $stable(filt_thr_i) |=> $stable(level_q));

endmodule

// File: rtl/tally_chan_dec.sv
module tally_chan_dec
  import tally_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               edge_lvl_i,
  input  logic               ctl_lvl_i,
  input  chan_cfg_t          cfg_i,
  output logic signed [1:0]  step_o
);

  logic             prev_q;
  logic             rise;
  logic             fall;
  edge_act_e        act;
  ctl_mode_e        mode;
  logic signed [1:0] raw_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= edge_lvl_i;
  end

  assign rise = edge_lvl_i & ~prev_q;
  assign fall = ~edge_lvl_i & prev_q;

  always_comb begin
    act = ACT_HOLD;
    if (rise)      act = cfg_i.rise_act;
    else if (fall) act = cfg_i.fall_act;
    case (act)
      ACT_INC: raw_step = 2'sd1;
      ACT_DEC: raw_step = -2'sd1;
      default: raw_step = 2'sd0;
    endcase
    mode = ctl_lvl_i ? cfg_i.hi_mode : cfg_i.lo_mode;
    case (mode)
      CM_KEEP: step_o = raw_step;
      CM_FLIP: step_o = -raw_step;
      default: step_o = 2'sd0;
    endcase
  end

  // R1: a channel steps only in a cycle where its conditioned edge level changed
  a_r1_step_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o != 2'sd0) |-> (edge_lvl_i != $past(edge_lvl_i)));

endmodule

// File: rtl/tally_cfg_regs.sv
module tally_cfg_regs
  import tally_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int FILT_W = 10,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output chan_cfg_t [NUM_CH-1:0]        ch_cfg_o,
  output logic signed [CNT_W-1:0]       lo_lim_o,
  output logic signed [CNT_W-1:0]       hi_lim_o,
  output logic signed [CNT_W-1:0]       thr0_o,
  output logic signed [CNT_W-1:0]       thr1_o,
  output logic                          filt_en_o,
  output logic [FILT_W-1:0]             filt_thr_o,
  output logic [N_EVT-1:0]              ev_en_o,
  output logic                          pause_o,
  output logic                          hold_zero_o,
  output logic                          stat_clr_o
);

  localparam int HALF   = DATA_W / 2;
  localparam int A_LIM  = NUM_CH;
  localparam int A_THR  = NUM_CH + 1;
  localparam int A_FILT = NUM_CH + 2;
  localparam int A_ACK  = NUM_CH + 3;
  localparam int A_RUN  = NUM_CH + 4;
  localparam logic signed [CNT_W-1:0] LO_RST = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic signed [CNT_W-1:0] HI_RST = {1'b0, {(CNT_W-1){1'b1}}};

  logic cfg_touch;
  logic ack_hit;

  assign cfg_touch  = we_i && (addr_i <= ADDR_W'(A_FILT));
  assign ack_hit    = we_i && (addr_i == ADDR_W'(A_ACK)) && wdata_i[0];
  assign stat_clr_o = cfg_touch || ack_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_cfg_o <= '0;
    end else if (we_i) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (addr_i == ADDR_W'(ch)) ch_cfg_o[ch] <= chan_cfg_t'(wdata_i[CHAN_CFG_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_lim_o    <= LO_RST;
      hi_lim_o    <= HI_RST;
      thr0_o      <= '0;
      thr1_o      <= '0;
      filt_en_o   <= 1'b0;
      filt_thr_o  <= '0;
      ev_en_o     <= '0;
      pause_o     <= 1'b0;
      hold_zero_o <= 1'b0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(A_LIM)) begin
        lo_lim_o <= wdata_i[CNT_W-1:0];
        hi_lim_o <= wdata_i[HALF +: CNT_W];
      end
      if (addr_i == ADDR_W'(A_THR)) begin
        thr0_o <= wdata_i[CNT_W-1:0];
        thr1_o <= wdata_i[HALF +: CNT_W];
      end
      if (addr_i == ADDR_W'(A_FILT)) begin
        filt_thr_o <= wdata_i[FILT_W-1:0];
        filt_en_o  <= wdata_i[FILT_W];
        ev_en_o    <= wdata_i[FILT_W+1 +: N_EVT];
      end
      if (addr_i == ADDR_W'(A_RUN)) begin
        pause_o     <= wdata_i[0];
        hold_zero_o <= wdata_i[1];
      end
    end
  end

endmodule

// File: rtl/tally_core.sv
module tally_core
  import tally_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int STEP_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [STEP_W-1:0] step_i,
  input  logic signed [CNT_W-1:0] lo_lim_i,
  input  logic signed [CNT_W-1:0] hi_lim_i,
  input  logic signed [CNT_W-1:0] thr0_i,
  input  logic signed [CNT_W-1:0] thr1_i,
  input  logic [N_EVT-1:0]        ev_en_i,
  input  logic                    pause_i,
  input  logic                    hold_zero_i,
  input  logic                    stat_clr_i,
  output logic signed [CNT_W-1:0] count_o,
  output logic [N_EVT-1:0]        status_o,
  output zero_mode_e              zmode_o,
  output logic                    irq_o
);

  localparam int EXT_W = CNT_W + 1;

  logic signed [CNT_W-1:0] count_q;
  logic [N_EVT-1:0]        status_q;
  zero_mode_e              zmode_q;

  logic signed [EXT_W-1:0] cur_ext, step_ext, nxt_ext, hi_ext, lo_ext;
  logic signed [CNT_W-1:0] cnt_new;
  logic                    advance, hit_hi, hit_lo;
  logic [N_EVT-1:0]        ev;

  always_comb begin
    cur_ext  = {count_q[CNT_W-1], count_q};
    step_ext = {{(EXT_W-STEP_W){step_i[STEP_W-1]}}, step_i};
    hi_ext   = {hi_lim_i[CNT_W-1], hi_lim_i};
    lo_ext   = {lo_lim_i[CNT_W-1], lo_lim_i};
    nxt_ext  = cur_ext + step_ext;
    advance  = !hold_zero_i && !pause_i && (step_i != '0);
    hit_hi   = (step_i > 0) && (nxt_ext >= hi_ext);
    hit_lo   = (step_i < 0) && (nxt_ext <= lo_ext);
    cnt_new  = (hit_hi || hit_lo) ? '0 : nxt_ext[CNT_W-1:0];
    ev       = '0;
    if (advance) begin
      ev[EVT_LO]   = hit_lo;
      ev[EVT_HI]   = hit_hi;
      ev[EVT_T0]   = (cnt_new == thr0_i) && (cnt_new != count_q);
      ev[EVT_T1]   = (cnt_new == thr1_i) && (cnt_new != count_q);
      ev[EVT_ZERO] = (cnt_new == '0) && (count_q != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      zmode_q  <= ZM_POS_TO_ZERO;
      status_q <= '0;
    end else begin
      if (hold_zero_i) begin
        count_q <= '0;
      end else if (advance) begin
        count_q <= cnt_new;
        if (cnt_new > 0)       zmode_q <= ZM_POS;
        else if (cnt_new < 0)  zmode_q <= ZM_NEG;
        else if (count_q > 0)  zmode_q <= ZM_POS_TO_ZERO;
        else if (count_q < 0)  zmode_q <= ZM_NEG_TO_ZERO;
      end
      status_q <= (stat_clr_i ? '0 : status_q) | (ev & ev_en_i);
    end
  end

  assign count_o  = count_q;
  assign status_o = status_q;
  assign zmode_o  = zmode_q;
  assign irq_o    = |status_q;

  // R12: hold-at-zero wins over everything
  a_r12_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hold_zero_i |=> (count_q == '0));

  // R11: a paused count keeps its value
  a_r11_pause_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_i && !hold_zero_i) |=> $stable(count_q));

  // R5: the high-limit status appears together with the wrap to zero
  a_r5_wrap_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[EVT_HI]) |-> (count_q == '0));

  // R5: same for the low limit
  a_r5_wrap_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[EVT_LO]) |-> (count_q == '0));

  // R8: a status bit only rises when its enable was set
  for (genvar k = 0; k < N_EVT; k++) begin : g_en_chk
    a_r8_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[k]) |-> $past(ev_en_i[k]));
  end

endmodule

// File: rtl/edge_tally_unit.sv
module edge_tally_unit
  import tally_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CNT_W       = 16,
  parameter int FILT_W      = 10,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [NUM_CH-1:0] edge_in,
  input  logic [NUM_CH-1:0] ctrl_in,
  output logic [CNT_W-1:0]  count_o,
  output logic [N_EVT-1:0]  status_o,
  output logic [1:0]        zero_mode_o,
  output logic              irq_o
);

  localparam int STEP_W = $clog2(NUM_CH + 1) + 1;

  chan_cfg_t [NUM_CH-1:0]  ch_cfg;
  logic signed [CNT_W-1:0] lo_lim, hi_lim, thr0, thr1, count_s;
  logic                    filt_en, pause, hold_zero, stat_clr;
  logic [FILT_W-1:0]       filt_thr;
  logic [N_EVT-1:0]        ev_en;
  logic signed [1:0]       ch_step [NUM_CH];
  logic signed [STEP_W-1:0] net_step;
  zero_mode_e              zmode;

  tally_cfg_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .FILT_W(FILT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr), .wdata_i(cfg_wdata),
    .ch_cfg_o(ch_cfg), .lo_lim_o(lo_lim), .hi_lim_o(hi_lim), .thr0_o(thr0), .thr1_o(thr1),
    .filt_en_o(filt_en), .filt_thr_o(filt_thr), .ev_en_o(ev_en), .pause_o(pause),
    .hold_zero_o(hold_zero), .stat_clr_o(stat_clr)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic edge_lvl, ctl_lvl;

    tally_sig_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_W(FILT_W)) u_edge_cond (
      .clk(clk), .rst_n(rst_n), .raw_i(edge_in[ch]), .invert_i(ch_cfg[ch].inv_edge),
      .filt_en_i(filt_en), .filt_thr_i(filt_thr), .level_o(edge_lvl)
    );

    tally_sig_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_W(FILT_W)) u_ctl_cond (
      .clk(clk), .rst_n(rst_n), .raw_i(ctrl_in[ch]), .invert_i(ch_cfg[ch].inv_ctl),
      .filt_en_i(filt_en), .filt_thr_i(filt_thr), .level_o(ctl_lvl)
    );

    tally_chan_dec u_dec (
      .clk(clk), .rst_n(rst_n), .edge_lvl_i(edge_lvl), .ctl_lvl_i(ctl_lvl),
      .cfg_i(ch_cfg[ch]), .step_o(ch_step[ch])
    );
  end

  // R4: all channel steps fold into one signed net step per cycle
  always_comb begin
    net_step = '0;
    for (int ch = 0; ch < NUM_CH; ch++) net_step = net_step + STEP_W'(ch_step[ch]);
  end

  tally_core #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step_i(net_step), .lo_lim_i(lo_lim), .hi_lim_i(hi_lim),
    .thr0_i(thr0), .thr1_i(thr1), .ev_en_i(ev_en), .pause_i(pause),
    .hold_zero_i(hold_zero), .stat_clr_i(stat_clr), .count_o(count_s),
    .status_o(status_o), .zmode_o(zmode), .irq_o(irq_o)
  );

  assign count_o     = count_s;
  assign zero_mode_o = zmode;

endmodule

// File: tb/edge_tally_unit_tb.sv
module edge_tally_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  e_pin = '0;
  logic [1:0]  c_pin = '0;
  logic [15:0] count_o;
  logic [4:0]  status_o;
  logic [1:0]  zero_mode_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  edge_tally_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .edge_in(e_pin), .ctrl_in(c_pin), .count_o(count_o), .status_o(status_o),
    .zero_mode_o(zero_mode_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [9:0]         c0;
    logic [9:0]         c1;
    logic               ctl0;
    logic               both;
    logic               end_high;
    logic [3:0]         pulses;
    logic signed [15:0] expv;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{10'h001, 10'h000, 1'b0, 1'b0, 1'b0, 4'd5,  16'sd5},  // R1 rise add
    '{10'h005, 10'h000, 1'b0, 1'b0, 1'b0, 4'd4,  16'sd8},  // R1 both edges add
    '{10'h002, 10'h000, 1'b0, 1'b0, 1'b0, 4'd3, -16'sd3},  // R1 rise subtract
    '{10'h011, 10'h000, 1'b0, 1'b0, 1'b0, 4'd3, -16'sd3},  // R2 low ctrl reverses
    '{10'h081, 10'h000, 1'b1, 1'b0, 1'b0, 4'd3,  16'sd0},  // R2 high ctrl suppresses
    '{10'h211, 10'h000, 1'b1, 1'b0, 1'b0, 4'd3, -16'sd3},  // R3 inverted ctrl
    '{10'h101, 10'h000, 1'b0, 1'b0, 1'b1, 4'd0,  16'sd0},  // R3 inverted edge, fall holds
    '{10'h104, 10'h000, 1'b0, 1'b0, 1'b1, 4'd0,  16'sd1},  // R3 inverted edge, fall adds
    '{10'h001, 10'h001, 1'b0, 1'b1, 1'b0, 4'd4,  16'sd8},  // R4 same-cycle sum
    '{10'h001, 10'h002, 1'b0, 1'b1, 1'b0, 4'd4,  16'sd0}   // R4 same-cycle cancel
  };

  function automatic string tag_of(int i);
    if (i < 3) return "R1";
    if (i < 5) return "R2";
    if (i < 8) return "R3";
    return "R4";
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(int n, bit both, int w);
    for (int k = 0; k < n; k++) begin
      e_pin[0] = 1'b1; if (both) e_pin[1] = 1'b1;
      idle(w);
      e_pin[0] = 1'b0; if (both) e_pin[1] = 1'b0;
      idle(w);
    end
  endtask

  task automatic zap();
    wr(3'd6, 32'h2);
    idle(3);
    wr(3'd6, 32'h0);
    idle(3);
  endtask

  task automatic quad(bit a, bit b);
    e_pin = {b, a};
    c_pin = {a, b};
    idle(8);
  endtask

  function automatic int cnt();
    return int'($signed(count_o));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R14 reset state
    check("R14 count", cnt(), 0);
    check("R14 status", int'(status_o), 0);
    check("R14 irq", int'(irq_o), 0);
    check("R14 zero_mode", int'(zero_mode_o), 0);
    rst_n = 1'b1;
    idle(3);

    for (int vi = 0; vi < NV; vi++) begin
      e_pin = '0; c_pin = '0;
      idle(10);
      wr(3'd0, {22'd0, VECS[vi].c0});
      wr(3'd1, {22'd0, VECS[vi].c1});
      c_pin[0] = VECS[vi].ctl0;
      idle(10);
      zap();
      pulse(int'(VECS[vi].pulses), VECS[vi].both, 8);
      if (VECS[vi].end_high) begin
        e_pin[0] = 1'b1;
        idle(8);
      end
      idle(10);
      check(tag_of(vi), cnt(), int'(VECS[vi].expv));
    end
    e_pin = '0; c_pin = '0;
    idle(10);

    // R13 quadrature
    wr(3'd0, 32'h016);
    wr(3'd1, 32'h019);
    idle(10);
    zap();
    for (int k = 0; k < 3; k++) begin
      quad(1, 0); quad(1, 1); quad(0, 1); quad(0, 0);
    end
    check("R13 forward", cnt(), 12);
    for (int k = 0; k < 2; k++) begin
      quad(0, 1); quad(1, 1); quad(1, 0); quad(0, 0);
    end
    check("R13 reverse", cnt(), 4);

    // R5 limits, R8 enables/irq, R9 clears
    wr(3'd1, 32'h000);
    wr(3'd0, 32'h001);
    wr(3'd2, {16'd5, 16'hFFFB});
    wr(3'd4, 32'h1800);
    zap();
    pulse(4, 0, 8);
    check("R5 below high", cnt(), 4);
    check("R8 no event yet", int'(status_o), 0);
    pulse(1, 0, 8);
    check("R5 high wrap", cnt(), 0);
    check("R8 high bit", int'(status_o), 2);
    check("R8 irq", int'(irq_o), 1);
    wr(3'd5, 32'h1);
    idle(2);
    check("R9 ack clears", int'(irq_o), 0);
    wr(3'd0, 32'h002);
    pulse(5, 0, 8);
    check("R5 low wrap", cnt(), 0);
    check("R8 low bit", int'(status_o), 1);
    wr(3'd0, 32'h002);
    idle(2);
    check("R9 cfg write clears", int'(status_o), 0);

    // R6 thresholds and zero, R7 zero mode
    wr(3'd2, {16'h03E8, 16'hFC18});
    wr(3'd3, {16'hFFFE, 16'h0003});
    wr(3'd4, 32'hE000);
    wr(3'd0, 32'h001);
    zap();
    pulse(3, 0, 8);
    check("R6 thr0 hit", int'(status_o), 4);
    check("R7 positive", int'(zero_mode_o), 3);
    wr(3'd0, 32'h002);
    pulse(3, 0, 8);
    check("R6 zero hit", int'(status_o), 16);
    check("R7 pos to zero", int'(zero_mode_o), 0);
    pulse(1, 0, 8);
    check("R7 negative", int'(zero_mode_o), 2);
    pulse(1, 0, 8);
    check("R6 thr1 hit", int'(status_o), 24);
    wr(3'd0, 32'h001);
    pulse(2, 0, 8);
    check("R7 neg to zero", int'(zero_mode_o), 1);
    check("R6 zero again", int'(status_o), 16);

    // R11 pause
    zap();
    pulse(2, 0, 8);
    wr(3'd6, 32'h1);
    pulse(3, 0, 8);
    check("R11 paused", cnt(), 2);
    wr(3'd6, 32'h0);
    pulse(1, 0, 8);
    check("R11 resumed", cnt(), 3);

    // R12 hold at zero
    wr(3'd6, 32'h3);
    pulse(2, 0, 8);
    check("R12 held", cnt(), 0);
    wr(3'd6, 32'h0);
    pulse(1, 0, 8);
    check("R12 released", cnt(), 1);

    // R10 glitch filter
    wr(3'd4, 32'h40A);
    zap();
    e_pin[0] = 1'b1; idle(4); e_pin[0] = 1'b0; idle(30);
    check("R10 short rejected", cnt(), 0);
    e_pin[0] = 1'b1; idle(20); e_pin[0] = 1'b0; idle(30);
    check("R10 long accepted", cnt(), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule